// File: doc/BRIEF.md
# Eight-Channel Split-Resolution PWM Converter

This block drives eight pulse-width-modulated pins that an external RC low-pass filter turns into DC control voltages. The first four channels are fine channels with 7-bit resolution. The last four are coarse channels with 6-bit resolution. One divide-by-three prescaler produces a base tick for every channel. A 7-bit and a 6-bit free-running counter step on that tick. Each channel compares its counter with a compare register. The compare register is reloaded from the channel's level register only when that group's counter wraps, so a period is never cut short or stretched.

Software writes through a plain single-cycle strobe. It sets the level registers, one inversion bit per resolution group and an eight-bit pin-mode mask. Each pin carries either its PWM wave or the matching bit of the general-purpose output bus `gpio_out`. The write port has no back-pressure. Every strobed write completes in the cycle it is presented and needs no handshake.

Top module: `pwm_dac_bank`

## Requirements
- R1: After reset all levels are 0, both inversion bits are 0 and the mode mask is 0, so every `pin_out[n]` equals `gpio_out[n]`.
- R2: One base tick occurs every 3 clock cycles. A channel's high phase therefore lasts exactly 3 clocks per level unit.
- R3: A fine channel (0 to 3) with level v and no inversion is high for 3*v clocks of every 384-clock period, and the high phase opens the period.
- R4: A coarse channel (4 to 7) with level v and no inversion is high for 3*v clocks of every 192-clock period.
- R5: Level 0 gives a constantly low wave. The largest level (127 fine, 63 coarse) is low for exactly one tick per period.
- R6: A new level takes effect only at the next wrap of its group's counter. The period in progress finishes with the old level.
- R7: Writing address 8 sets the inversion bits. Bit 0 controls the fine group and bit 1 controls the coarse group, and 1 inverts the wave.
- R8: Writing address 9 sets the mode mask, with bit n for channel n. A 1 routes the PWM wave to `pin_out[n]`, and a 0 routes `gpio_out[n]`.
- R9: Addresses 0 to 7 write the level of the channel with that number, and only the low 7 (fine) or 6 (coarse) data bits are kept. Writes to addresses 10 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| gpio_out | input | 8 | General-purpose levels shown on pins in GPIO mode |
| pin_out | output | 8 | Pin levels after the PWM/GPIO selection |

## Verification
The high time is counted over one full 384-clock window. That window holds one fine period and two coarse periods, so the count does not depend on phase. Levels of 0, 1, mid-scale, full-scale and over-range data are applied, which separates a wrong counter width, a wrong compare direction and a lost mask. Inversion is applied to one group at a time to show that the two bits are independent. A mixed mode mask with a distinct GPIO pattern shows which source reaches each pin. A write made just after a rising edge, followed by a check partway through that period, shows whether the compare update waits for the wrap.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // bit position of each group's inversion flag in the polarity register
  typedef enum logic [0:0] {
    GRP_FINE   = 1'b0,
    GRP_COARSE = 1'b1
  } grp_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIV = 3,
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= '0;
    else if (cnt == CW'(DIV - 1))  cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == CW'(DIV - 1));

  AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(DIV)); // R2

  generate
    if (DIV > 1) begin : g_space
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
    end
  endgenerate
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NUM_HI  = 4,
  parameter int NUM_LO  = 4,
  parameter int HI_BITS = 7,
  parameter int LO_BITS = 6,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  localparam int NCH    = NUM_HI + NUM_LO
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_HI-1:0][HI_BITS-1:0]   hi_val,
  output logic [NUM_LO-1:0][LO_BITS-1:0]   lo_val,
  output logic                             inv_hi,
  output logic                             inv_lo,
  output logic [NCH-1:0]                   ch_en
);
  localparam logic [ADDR_W-1:0] ADDR_POL = ADDR_W'(NCH);
  localparam logic [ADDR_W-1:0] ADDR_EN  = ADDR_W'(NCH + 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_val <= '0;
      lo_val <= '0;
      inv_hi <= 1'b0;
      inv_lo <= 1'b0;
      ch_en  <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_HI; i++)
        if (wr_addr == ADDR_W'(i)) hi_val[i] <= wr_data[HI_BITS-1:0];
      for (int j = 0; j < NUM_LO; j++)
        if (wr_addr == ADDR_W'(NUM_HI + j)) lo_val[j] <= wr_data[LO_BITS-1:0];
      if (wr_addr == ADDR_POL) begin
        inv_hi <= wr_data[GRP_FINE];
        inv_lo <= wr_data[GRP_COARSE];
      end
      if (wr_addr == ADDR_EN) ch_en <= wr_data[NCH-1:0];
    end
  end

  AST_MASK_ON_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == ADDR_EN) |=> $stable(ch_en)); // R8

  AST_INV_ON_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == ADDR_POL) |=> ($stable(inv_hi) && $stable(inv_lo))); // R7

  AST_SPARE_ADDR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > ADDR_EN) |=>
      ($stable(hi_val) && $stable(lo_val) && $stable(ch_en))); // R9
endmodule

// File: rtl/pwm_group.sv
module pwm_group #(
  parameter int N    = 4,
  parameter int BITS = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic [N-1:0][BITS-1:0] level,
  input  logic                   invert,
  output logic [N-1:0]           wave
);
  logic [BITS-1:0]         cnt;
  logic                    wrap;
  logic [N-1:0][BITS-1:0]  cmp;
  logic [N-1:0]            raw;

  assign wrap = tick && (cnt == '1);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  // compare registers reload only at the period boundary
  always_ff @(posedge clk) begin
    if (!rst_n)    cmp <= '0;
    else if (wrap) cmp <= level;
  end

  AST_CNT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt)); // R2

  AST_CMP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(cmp)); // R6

  generate
    for (genvar i = 0; i < N; i++) begin : g_ch
      assign raw[i]  = (cnt < cmp[i]);
      assign wave[i] = raw[i] ^ invert;

      AST_ZERO_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp[i] == '0) |-> !raw[i]); // R5

      AST_LAST_TICK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '1) |-> !raw[i]); // R5

      AST_PERIOD_OPENS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && cmp[i] != '0) |-> raw[i]); // R3
    end
  endgenerate
endmodule

// File: rtl/pwm_dac_bank.sv
module pwm_dac_bank #(
  parameter int NUM_HI  = 4,
  parameter int NUM_LO  = 4,
  parameter int HI_BITS = 7,
  parameter int LO_BITS = 6,
  parameter int CLK_DIV = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  localparam int NCH    = NUM_HI + NUM_LO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NCH-1:0]    gpio_out,
  output logic [NCH-1:0]    pin_out
);
  logic                           tick;
  logic [NUM_HI-1:0][HI_BITS-1:0] hi_val;
  logic [NUM_LO-1:0][LO_BITS-1:0] lo_val;
  logic                           inv_hi;
  logic                           inv_lo;
  logic [NCH-1:0]                 ch_en;
  logic [NUM_HI-1:0]              hi_wave;
  logic [NUM_LO-1:0]              lo_wave;
  logic [NCH-1:0]                 wave_all;

  pwm_prescaler #(.DIV(CLK_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  pwm_regs #(
    .NUM_HI(NUM_HI), .NUM_LO(NUM_LO), .HI_BITS(HI_BITS), .LO_BITS(LO_BITS),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hi_val(hi_val), .lo_val(lo_val),
    .inv_hi(inv_hi), .inv_lo(inv_lo), .ch_en(ch_en)
  );

  pwm_group #(.N(NUM_HI), .BITS(HI_BITS)) u_fine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .level(hi_val),
    .invert(inv_hi), .wave(hi_wave)
  );

  pwm_group #(.N(NUM_LO), .BITS(LO_BITS)) u_coarse (
    .clk(clk), .rst_n(rst_n), .tick(tick), .level(lo_val),
    .invert(inv_lo), .wave(lo_wave)
  );

  assign wave_all = {lo_wave, hi_wave};

  generate
    for (genvar n = 0; n < NCH; n++) begin : g_pin
      assign pin_out[n] = ch_en[n] ? wave_all[n] : gpio_out[n];

      AST_GPIO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en[n] |-> (pin_out[n] == gpio_out[n])); // R8
    end
  endgenerate
endmodule

// File: tb/tb_pwm_dac_bank.sv
module tb_pwm_dac_bank;
  localparam int WIN = 384;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] gpio_out;
  logic [7:0] pin_out;

  int n_chk = 0;
  int n_bad = 0;

  // bench-side register model
  int       m_val [8];
  logic [1:0] m_inv;
  logic [7:0] m_en;

  typedef struct { string req; int ch; int cnt; } exp_t;
  exp_t exp_q [$];

  always #10 clk = ~clk;

  pwm_dac_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .gpio_out(gpio_out), .pin_out(pin_out)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
    if (addr < 8)       m_val[addr] = data;
    else if (addr == 8) m_inv = 2'(data);
    else if (addr == 9) m_en  = 8'(data);
  endtask

  // driver side: push the high-clock count expected per channel over WIN clocks
  task automatic push_model(string ovr);
    for (int ch = 0; ch < 8; ch++) begin
      exp_t e;
      int v, mx, hi;
      bit fine;
      fine = (ch < 4);
      mx   = fine ? 127 : 63;
      v    = m_val[ch] & mx;
      hi   = fine ? 3 * v : 6 * v;
      if (fine ? m_inv[0] : m_inv[1]) hi = WIN - hi;
      if (!m_en[ch]) hi = gpio_out[ch] ? WIN : 0;
      e.ch  = ch;
      e.cnt = hi;
      if (ovr != "")               e.req = ovr;
      else if (v == 0 || v == mx)  e.req = "R5";
      else                         e.req = fine ? "R3" : "R4";
      exp_q.push_back(e);
    end
  endtask

  // monitor side: measure one window, pop and compare
  task automatic sample_compare();
    int act [8];
    for (int ch = 0; ch < 8; ch++) act[ch] = 0;
    repeat (WIN) begin
      @(negedge clk);
      for (int ch = 0; ch < 8; ch++) act[ch] += int'(pin_out[ch]);
    end
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk($sformatf("%s ch%0d", e.req, e.ch), act[e.ch], e.cnt);
    end
  endtask

  task automatic settle();
    repeat (2 * WIN + 16) @(negedge clk);
  endtask

  task automatic wait_rise0();
    logic prev;
    @(negedge clk); prev = pin_out[0];
    forever begin
      @(negedge clk);
      if (!prev && pin_out[0]) break;
      prev = pin_out[0];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int run;
    for (int ch = 0; ch < 8; ch++) m_val[ch] = 0;
    m_inv = '0; m_en = '0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    gpio_out = 8'hA5;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pins follow gpio", int'(pin_out), 'hA5);
    gpio_out = 8'h3C;
    @(negedge clk);
    chk("R1 pins follow gpio change", int'(pin_out), 'h3C);
    push_model("R1");
    sample_compare();

    // mixed levels incl. over-range data, all pins in PWM mode
    wr(0, 0); wr(1, 8'hFF); wr(2, 64); wr(3, 1);
    wr(4, 0); wr(5, 8'hFF); wr(6, 32); wr(7, 5);
    wr(9, 8'hFF);
    settle();
    push_model("");
    sample_compare();

    // mask check on over-range writes
    wr(1, 8'h85); wr(5, 8'hC9);
    settle();
    push_model("R9");
    sample_compare();

    // inversion per group
    wr(8, 1);
    settle();
    push_model("R7");
    sample_compare();
    wr(8, 2);
    settle();
    push_model("R7");
    sample_compare();
    wr(8, 0);

    // partial PWM mode
    gpio_out = 8'h0F;
    wr(9, 8'h5A);
    settle();
    push_model("R8");
    sample_compare();
    wr(9, 8'hFF);

    // spare addresses must not disturb anything
    for (int a = 10; a < 16; a++) wr(a, (a & 1) ? 8'h00 : 8'hFF);
    settle();
    push_model("R9");
    sample_compare();

    // exact high-phase length: level 64 -> 192 consecutive clocks
    wr(0, 64);
    settle();
    wait_rise0();
    run = 1;
    forever begin
      @(negedge clk);
      if (!pin_out[0]) break;
      run++;
    end
    chk("R2 ch0 high run", run, 192);

    // mid-period write must not cut the running period
    wait_rise0();
    wr(0, 10);
    repeat (100) @(negedge clk);
    chk("R6 ch0 still high", int'(pin_out[0]), 1);
    settle();
    push_model("R6");
    sample_compare();

    summary();
    $finish;
  end
endmodule